// File: doc/BRIEF.md
# FFT-based Hilbert transformer

This block takes a frame of real, uniformly spaced samples and returns the Hilbert transform of that frame, sample by sample, in time order. Internally it runs a radix-2 decimation-in-time FFT on the frame. It then multiplies every frequency bin by -j·sgn(k). It finishes with an inverse FFT that reuses the same single butterfly datapath with conjugated twiddle factors. The frame length N is a power of two (default 16). Samples are 16-bit signed. Twiddle factors are Q1.15 values computed when the design elaborates.

Samples enter one per accepted handshake on a valid/ready input. The block stops accepting input while a frame is in flight. Results leave on a valid/ready output as a real part and an imaginary part. The imaginary part stays near zero for a real input. A one-cycle pulse accompanies the handshake of the last result of each frame. The 1/N factor of the inverse transform is applied as a rounded halving after every forward butterfly stage, so the inverse stages run unscaled.

Top module: `hilbert_fft_xform`

## Requirements
- R1: After reset, in_ready is 1, out_valid is 0 and frame_done is 0.
- R2: A frame is exactly N accepted input samples. From the handshake of the N-th sample until the last output handshake of that frame, in_ready is 0, and in_valid and in_sample have no effect on the results. in_ready and out_valid are never 1 together.
- R3: A cosine input at bin m, with 1 ≤ m ≤ N/2-1, x[n] = A·cos(2πmn/N), produces out_re[n] = A·sin(2πmn/N) within a tolerance of 16 LSB.
- R4: A sine input at bin m, with 1 ≤ m ≤ N/2-1, produces out_re[n] = -A·cos(2πmn/N) within 16 LSB.
- R5: A constant (DC) input produces out_re within 16 LSB of zero. An alternating input at bin N/2, A·(-1)^n, also produces out_re within 16 LSB of zero.
- R6: The transform is linear. A sum of a DC term, a cosine at one bin and a sine at another bin produces the sum of the separate results, within 16 LSB.
- R7: For every real input frame, out_im stays within 16 LSB of zero.
- R8: While out_valid is 1 and out_ready is 0, out_valid, out_re and out_im hold their values into the next cycle.
- R9: Results appear in index order 0 to N-1. frame_done is 1 in exactly one cycle per frame: the cycle of the handshake of result N-1. out_valid is 0 in the cycle after that handshake.
- R10: out_valid rises exactly N·log2(N)+1 clock edges after the edge that accepts the last input sample of the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block accepts an input sample |
| in_sample | input | DW | Signed input sample |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer accepts the result |
| out_re | output | DW | Real part of result, saturated |
| out_im | output | DW | Imaginary part of result, saturated |
| frame_done | output | 1 | Pulse with the handshake of the last result |

## Verification
The assertions check the handshake rules on every cycle: input and output never open together, the input closes after the N-th sample, stalled results hold still, the done pulse lands only on a completed handshake, and the fixed latency from the last input to the first result. The numerical behaviour can only be shown by the bench's scenarios. These are the sign flip that turns cosines into sines and sines into negative cosines at every bin below Nyquist, the removal of DC and Nyquist content, superposition, and the near-zero imaginary part. The bench compares these against values it computes from trigonometric expressions. The bench also shows that input presented during processing is ignored, and it applies stalls on the output.

// File: rtl/hilb_pkg.sv
// Package for the FFT Hilbert transformer.
// Holds the controller state type and the bit-reversal helper.
// Assumes index widths are at most 31 bits.
package hilb_pkg;

    typedef enum logic [2:0] {
        ST_LOAD = 3'd0,
        ST_FWD  = 3'd1,
        ST_SPEC = 3'd2,
        ST_INV  = 3'd3,
        ST_OUT  = 3'd4
    } hx_state_t;

    // Reverse the low 'bits' bits of v.
    function automatic int unsigned bit_rev(input int unsigned v, input int unsigned bits);
        int unsigned r;
        r = 0;
        for (int unsigned i = 0; i < bits; i++) begin
            r = (r << 1) | ((v >> i) & 1);
        end
        return r;
    endfunction

endpackage

// File: rtl/hilb_twiddle_rom.sv
// Twiddle-factor lookup for an N-point radix-2 transform.
// Returns W = exp(-j*2*pi*k/N) in Q1.(TW-1) for the forward pass. With
// 'inverse' set it returns the conjugate. The table is computed during
// elaboration. Assumes N is a power of two and N >= 4.
module hilb_twiddle_rom #(
    parameter int N  = 16,
    parameter int TW = 16
) (
    input  logic [$clog2(N)-2:0]  idx,
    input  logic                  inverse,
    output logic signed [TW-1:0]  w_re,
    output logic signed [TW-1:0]  w_im
);
    localparam int HALF = N / 2;
    localparam real TWO_PI = 6.283185307179586;
    localparam real QSCALE = (2.0 ** (TW - 1)) - 1.0;

    // Rounded cosine sample for table entry k.
    function automatic logic signed [TW-1:0] q_cos(input int k);
        real a;
        a = TWO_PI * k / N;
        return TW'($rtoi($floor(QSCALE * $cos(a) + 0.5)));
    endfunction

    // Rounded sine sample for table entry k.
    function automatic logic signed [TW-1:0] q_sin(input int k);
        real a;
        a = TWO_PI * k / N;
        return TW'($rtoi($floor(QSCALE * $sin(a) + 0.5)));
    endfunction

    logic signed [TW-1:0] rom_c [HALF];
    logic signed [TW-1:0] rom_s [HALF];

    for (genvar k = 0; k < HALF; k++) begin : g_rom
        assign rom_c[k] = q_cos(k);
        assign rom_s[k] = q_sin(k);
    end

    // Select the entry and apply conjugation for the inverse pass.
    always_comb begin
        w_re = rom_c[idx];
        w_im = inverse ? rom_s[idx] : -rom_s[idx];
    end

endmodule

// File: rtl/hilb_butterfly.sv
// Radix-2 decimation-in-time butterfly, purely combinational.
// p = a + w*b and q = a - w*b. When 'halve' is set, both results are
// halved with rounding (forward pass). The twiddle is Q1.(TW-1). Assumes
// the caller keeps enough guard bits in IW that results fit IW bits.
module hilb_butterfly #(
    parameter int IW = 18,
    parameter int TW = 16
) (
    input  logic signed [IW-1:0] a_re,
    input  logic signed [IW-1:0] a_im,
    input  logic signed [IW-1:0] b_re,
    input  logic signed [IW-1:0] b_im,
    input  logic signed [TW-1:0] w_re,
    input  logic signed [TW-1:0] w_im,
    input  logic                 halve,
    output logic signed [IW-1:0] p_re,
    output logic signed [IW-1:0] p_im,
    output logic signed [IW-1:0] q_re,
    output logic signed [IW-1:0] q_im
);
    localparam int MW = IW + TW;
    localparam int PW = MW + 1;
    localparam int EW = IW + 2;
    localparam logic signed [PW-1:0] RND_M = PW'(1) <<< (TW - 2);
    localparam logic signed [EW-1:0] ONE   = EW'(1);

    logic signed [MW-1:0] rr, ii, ri, ir;
    logic signed [PW-1:0] sum_re, sum_im;
    logic signed [EW-1:0] t_re, t_im, a_re_x, a_im_x;
    logic signed [EW-1:0] sp_re, sp_im, sq_re, sq_im;
    logic signed [EW-1:0] hp_re, hp_im, hq_re, hq_im;

    // Complex product w*b with rounding back to sample scale.
    always_comb begin
        rr     = MW'(b_re) * MW'(w_re);
        ii     = MW'(b_im) * MW'(w_im);
        ri     = MW'(b_re) * MW'(w_im);
        ir     = MW'(b_im) * MW'(w_re);
        sum_re = PW'(rr) - PW'(ii) + RND_M;
        sum_im = PW'(ri) + PW'(ir) + RND_M;
        t_re   = EW'(sum_re >>> (TW - 1));
        t_im   = EW'(sum_im >>> (TW - 1));
    end

    // Sum and difference, optionally halved with rounding.
    always_comb begin
        a_re_x = EW'(a_re);
        a_im_x = EW'(a_im);
        sp_re  = a_re_x + t_re;
        sp_im  = a_im_x + t_im;
        sq_re  = a_re_x - t_re;
        sq_im  = a_im_x - t_im;
        hp_re  = halve ? ((sp_re + ONE) >>> 1) : sp_re;
        hp_im  = halve ? ((sp_im + ONE) >>> 1) : sp_im;
        hq_re  = halve ? ((sq_re + ONE) >>> 1) : sq_re;
        hq_im  = halve ? ((sq_im + ONE) >>> 1) : sq_im;
        p_re   = IW'(hp_re);
        p_im   = IW'(hp_im);
        q_re   = IW'(hq_re);
        q_im   = IW'(hq_im);
    end

endmodule

// File: rtl/hilb_spectral_sign.sv
// Spectral stage of the Hilbert transformer, purely combinational.
// Takes the natural-order spectrum. Bins 1..N/2-1 are multiplied by -j,
// bins N/2+1..N-1 by +j, and bins 0 and N/2 become zero. Each result is
// placed at the bit-reversed address, ready for the in-place DIT inverse
// pass. Assumes N is a power of two and N >= 4.
module hilb_spectral_sign #(
    parameter int N  = 16,
    parameter int IW = 18
) (
    input  logic signed [IW-1:0] src_re [N],
    input  logic signed [IW-1:0] src_im [N],
    output logic signed [IW-1:0] dst_re [N],
    output logic signed [IW-1:0] dst_im [N]
);
    localparam int LOGN = $clog2(N);
    localparam int HALF = N / 2;

    for (genvar k = 0; k < N; k++) begin : g_bin
        localparam int DST = int'(hilb_pkg::bit_rev(k, LOGN));
        if (k == 0 || k == HALF) begin : g_zero
            assign dst_re[DST] = '0;
            assign dst_im[DST] = '0;
        end else if (k < HALF) begin : g_pos
            assign dst_re[DST] = src_im[k];
            assign dst_im[DST] = -src_re[k];
        end else begin : g_neg
            assign dst_re[DST] = -src_im[k];
            assign dst_im[DST] = src_re[k];
        end
    end

endmodule

// File: rtl/hilbert_fft_xform.sv
// FFT-based Hilbert transformer, top level.
// Accepts N real samples and stores them at bit-reversed addresses. It runs
// log2(N) forward DIT stages with per-stage halving, one cycle of spectral
// sign multiplication with re-permutation, and log2(N) inverse stages with
// conjugate twiddles and no scaling. It then streams N results in natural
// order. One butterfly is done per cycle. Assumes N is a power of two,
// N >= 4, and GUARD >= 2.
module hilbert_fft_xform #(
    parameter int N     = 16,
    parameter int DW    = 16,
    parameter int TW    = 16,
    parameter int GUARD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [DW-1:0] in_sample,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [DW-1:0] out_re,
    output logic [DW-1:0] out_im,
    output logic          frame_done
);
    import hilb_pkg::*;

    localparam int LOGN = $clog2(N);
    localparam int KW   = LOGN - 1;
    localparam int SW   = (LOGN > 2) ? $clog2(LOGN) : 1;
    localparam int IW   = DW + GUARD;
    localparam int HALF = N / 2;
    localparam int LAT  = (N / 2) * LOGN * 2 + 1;
    localparam logic [LOGN-1:0] LAST_IDX = LOGN'(N - 1);
    localparam logic [KW-1:0]   LAST_BF  = KW'(HALF - 1);
    localparam logic [SW-1:0]   LAST_STG = SW'(LOGN - 1);
    localparam logic signed [IW-1:0] SAT_HI = IW'((2 ** (DW - 1)) - 1);
    localparam logic signed [IW-1:0] SAT_LO = -IW'(2 ** (DW - 1));

    hx_state_t state_q;
    logic [LOGN-1:0] idx_q;
    logic [KW-1:0]   bf_q;
    logic [SW-1:0]   stg_q;

    logic signed [IW-1:0] mem_re [N];
    logic signed [IW-1:0] mem_im [N];
    logic signed [IW-1:0] spec_re [N];
    logic signed [IW-1:0] spec_im [N];

    logic [LOGN-1:0] top_a, bot_a;
    logic [KW-1:0]   tw_idx;
    logic            inv_pass;
    logic signed [TW-1:0] w_re, w_im;
    logic signed [IW-1:0] p_re, p_im, q_re, q_im;
    logic            in_fire, out_fire;

    // Saturate an internal value to the output width.
    function automatic logic [DW-1:0] sat_out(input logic signed [IW-1:0] v);
        if (v > SAT_HI) return DW'(SAT_HI);
        if (v < SAT_LO) return DW'(SAT_LO);
        return DW'(v);
    endfunction

    // Handshake qualifiers.
    always_comb begin
        in_ready   = (state_q == ST_LOAD);
        out_valid  = (state_q == ST_OUT);
        in_fire    = in_valid && in_ready;
        out_fire   = out_valid && out_ready;
        frame_done = out_fire && (idx_q == LAST_IDX);
        inv_pass   = (state_q == ST_INV);
    end

    // Butterfly addressing for stage stg_q, butterfly bf_q.
    always_comb begin
        int s, b, span, pos, grp;
        s      = int'(stg_q);
        b      = int'(bf_q);
        span   = 1 << s;
        pos    = b & (span - 1);
        grp    = b >> s;
        top_a  = LOGN'((grp << (s + 1)) | pos);
        bot_a  = LOGN'((grp << (s + 1)) | pos | span);
        tw_idx = KW'(pos << (LOGN - 1 - s));
    end

    hilb_twiddle_rom #(.N(N), .TW(TW)) u_rom (
        .idx     (tw_idx),
        .inverse (inv_pass),
        .w_re    (w_re),
        .w_im    (w_im)
    );

    hilb_butterfly #(.IW(IW), .TW(TW)) u_bfly (
        .a_re  (mem_re[top_a]),
        .a_im  (mem_im[top_a]),
        .b_re  (mem_re[bot_a]),
        .b_im  (mem_im[bot_a]),
        .w_re  (w_re),
        .w_im  (w_im),
        .halve (!inv_pass),
        .p_re  (p_re),
        .p_im  (p_im),
        .q_re  (q_re),
        .q_im  (q_im)
    );

    hilb_spectral_sign #(.N(N), .IW(IW)) u_spec (
        .src_re (mem_re),
        .src_im (mem_im),
        .dst_re (spec_re),
        .dst_im (spec_im)
    );

    // Controller: frame load, two butterfly passes, spectral step, drain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_LOAD;
            idx_q   <= '0;
            bf_q    <= '0;
            stg_q   <= '0;
        end else begin
            case (state_q)
                ST_LOAD: if (in_fire) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) state_q <= ST_FWD;
                end
                ST_FWD, ST_INV: begin
                    bf_q <= bf_q + 1'b1;
                    if (bf_q == LAST_BF) begin
                        bf_q  <= '0;
                        stg_q <= stg_q + 1'b1;
                        if (stg_q == LAST_STG) begin
                            stg_q   <= '0;
                            state_q <= (state_q == ST_FWD) ? ST_SPEC : ST_OUT;
                        end
                    end
                end
                ST_SPEC: state_q <= ST_INV;
                ST_OUT: if (out_fire) begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == LAST_IDX) state_q <= ST_LOAD;
                end
                default: state_q <= ST_LOAD;
            endcase
        end
    end

    // Frame memory: load, in-place butterflies, spectral rewrite.
    always_ff @(posedge clk) begin
        case (state_q)
            ST_LOAD: if (in_fire) begin
                mem_re[LOGN'(bit_rev(int'(idx_q), LOGN))] <= IW'($signed(in_sample));
                mem_im[LOGN'(bit_rev(int'(idx_q), LOGN))] <= '0;
            end
            ST_FWD, ST_INV: begin
                mem_re[top_a] <= p_re;
                mem_im[top_a] <= p_im;
                mem_re[bot_a] <= q_re;
                mem_im[bot_a] <= q_im;
            end
            ST_SPEC: begin
                mem_re <= spec_re;
                mem_im <= spec_im;
            end
            default: ;
        endcase
    end

    // Result selection in natural order.
    always_comb begin
        out_re = sat_out(mem_re[idx_q]);
        out_im = sat_out(mem_im[idx_q]);
    end

    // Cycles since the last input sample, for the latency check.
    logic [15:0] lat_q;
    always_ff @(posedge clk) begin
        if (!rst_n) lat_q <= '0;
        else if (in_fire) lat_q <= '0;
        else if (state_q == ST_FWD || state_q == ST_SPEC || state_q == ST_INV)
            lat_q <= lat_q + 1'b1;
    end

    // R2: the two sides of the block never open together.
    p_ports_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_ready && out_valid));

    // R2: the input closes once the last sample of a frame is taken.
    p_close_after_last_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_fire && idx_q == LAST_IDX) |=> (!in_ready && !out_valid));

    // R8: a stalled result holds still.
    p_hold_stalled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_re) && $stable(out_im)));

    // R9: the done pulse rides a real handshake and lasts one cycle.
    p_done_on_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> (out_valid && out_ready));

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> (!frame_done && !out_valid && in_ready));

    // R10: first result appears after the fixed processing latency.
    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> (lat_q == 16'(LAT)));

endmodule

// File: tb/hilbert_fft_xform_bench.sv
// Bench for the FFT Hilbert transformer. It sweeps every bin below Nyquist
// with cosine and sine inputs, adds DC, Nyquist and mixed frames, and
// compares against expected values computed from trigonometry. Inputs are
// driven and outputs sampled on the falling edge.
module hilbert_fft_xform_bench;
    localparam int N    = 16;
    localparam int DW   = 16;
    localparam int LOGN = 4;
    localparam int LAT  = N * LOGN + 1;
    localparam int TOL  = 16;
    localparam real TWO_PI = 6.283185307179586;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic in_ready;
    logic [DW-1:0] in_sample = '0;
    logic out_valid;
    logic out_ready = 1'b0;
    logic [DW-1:0] out_re, out_im;
    logic frame_done;

    int n_cmp = 0;
    int n_bad = 0;
    int stim [N];
    real expv [N];

    always #2 clk = ~clk;

    hilbert_fft_xform u_hilbert_fft_xform (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_ready   (in_ready),
        .in_sample  (in_sample),
        .out_valid  (out_valid),
        .out_ready  (out_ready),
        .out_re     (out_re),
        .out_im     (out_im),
        .frame_done (frame_done)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Send stim, measure latency, drain with optional stalls, compare to expv.
    task automatic run_frame(input string req, input bit stall);
        int cyc, got, dcount, t;
        bit prev_stall;
        logic [DW-1:0] hold_re, hold_im;
        int ready_miss;
        for (int i = 0; i < N; i++) begin
            @(negedge clk);
            if (i == 0) check(in_ready == 1'b1, "R2 open for load", int'(in_ready), 1);
            in_valid  = 1'b1;
            in_sample = DW'(stim[i]);
        end
        @(negedge clk);
        // R2: junk offered during processing must be ignored.
        in_sample  = 16'h7abc;
        check(in_ready == 1'b0, "R2 closed after last sample", int'(in_ready), 0);
        cyc = 0;
        ready_miss = 0;
        while (!out_valid) begin
            if (in_ready) ready_miss++;
            @(negedge clk);
            cyc++;
        end
        in_valid = 1'b0;
        check(ready_miss == 0, "R2 in_ready low while busy", ready_miss, 0);
        check(cyc == LAT, "R10 latency", cyc, LAT);
        got = 0;
        dcount = 0;
        t = 0;
        prev_stall = 1'b0;
        hold_re = '0;
        hold_im = '0;
        while (got < N) begin
            out_ready = stall ? ((t % 3) != 1) : 1'b1;
            t++;
            #0.5;
            if (prev_stall) begin
                check(out_valid && out_re == hold_re && out_im == hold_im,
                      "R8 hold while stalled", int'($signed(out_re)), int'($signed(hold_re)));
            end
            check(in_ready == 1'b0, "R2 no load during drain", int'(in_ready), 0);
            if (out_valid && out_ready) begin
                check($signed(out_re) - int'($floor(expv[got] + 0.5)) <= TOL &&
                      int'($floor(expv[got] + 0.5)) - $signed(out_re) <= TOL,
                      req, int'($signed(out_re)), int'($floor(expv[got] + 0.5)));
                check($signed(out_im) <= TOL && $signed(out_im) >= -TOL,
                      "R7 imaginary near zero", int'($signed(out_im)), 0);
                if (frame_done) begin
                    dcount++;
                    check(got == N - 1, "R9 done on last result", got, N - 1);
                end
                got++;
                prev_stall = 1'b0;
            end else begin
                prev_stall = out_valid;
                hold_re = out_re;
                hold_im = out_im;
            end
            @(negedge clk);
        end
        out_ready = 1'b0;
        #0.5;
        check(dcount == 1, "R9 one done pulse per frame", dcount, 1);
        check(out_valid == 1'b0, "R9 output closed after frame", int'(out_valid), 0);
        check(in_ready == 1'b1, "R2 reopened for next frame", int'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state.
        check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
        check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
        check(frame_done == 1'b0, "R1 frame_done after reset", int'(frame_done), 0);
        rst_n = 1'b1;

        // R3: cosine at every bin below Nyquist gives sine.
        for (int m = 1; m < N / 2; m++) begin
            for (int n = 0; n < N; n++) begin
                stim[n] = int'($floor(8000.0 * $cos(TWO_PI * m * n / N) + 0.5));
                expv[n] = 8000.0 * $sin(TWO_PI * m * n / N);
            end
            run_frame("R3 cosine to sine", m[0]);
        end

        // R4: sine at every bin below Nyquist gives negative cosine.
        for (int m = 1; m < N / 2; m++) begin
            for (int n = 0; n < N; n++) begin
                stim[n] = int'($floor(7000.0 * $sin(TWO_PI * m * n / N) + 0.5));
                expv[n] = -7000.0 * $cos(TWO_PI * m * n / N);
            end
            run_frame("R4 sine to minus cosine", !m[0]);
        end

        // R5: DC input is removed.
        for (int n = 0; n < N; n++) begin
            stim[n] = 10000;
            expv[n] = 0.0;
        end
        run_frame("R5 DC removed", 1'b0);

        // R5: Nyquist input is removed.
        for (int n = 0; n < N; n++) begin
            stim[n] = n[0] ? -10000 : 10000;
            expv[n] = 0.0;
        end
        run_frame("R5 Nyquist removed", 1'b1);

        // R6: superposition of DC, cosine at bin 2 and sine at bin 5.
        for (int n = 0; n < N; n++) begin
            stim[n] = int'($floor(3000.0 + 6000.0 * $cos(TWO_PI * 2 * n / N)
                                 + 5000.0 * $sin(TWO_PI * 5 * n / N) + 0.5));
            expv[n] = 6000.0 * $sin(TWO_PI * 2 * n / N) - 5000.0 * $cos(TWO_PI * 5 * n / N);
        end
        run_frame("R6 superposition", 1'b1);

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule